// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This controller decides which power mode a small microcontroller is in and drives the enables that make that mode real. It controls the core clock, the peripheral clock, two high-frequency oscillators, the regulator bias, the internal power nets and pin retention. Software selects a mode by writing one of two 2-bit control registers while the device runs. The controller then holds the mode until one of the exit conditions for that mode appears on its inputs.

There are two clock-halt modes, suspend and snooze. They are identical except for the regulator bias. Entry to either is refused unless the system clock already comes from the primary high-frequency oscillator.

There are also two power-off modes, stop and shutdown. The deep-off select input, sampled at the write, picks between them. Any reset cause ends stop. Only a power-on or pin reset ends shutdown.

When the device leaves a clock-halt or power-off mode, the controller first turns the oscillators back on in a wake state. It releases the clocks only once the oscillator reports ready, so execution resumes where it stopped.

Top module: `pwr_mode_seq`

## Requirements
- R1: After `rst_n` is deasserted, `mode` is 0 (run) and `clkhalt_err` is 0. The run outputs are: both clock enables 1, both oscillator enables 1, `reg_low_bias` 0, `pwr_net_en` 1 and `pin_retain` 0.
- R2: In run, a write with `wr_sel`=0 and `wr_data[0]`=1 enters idle (mode 1). In idle the core clock is off, and the peripheral clock and oscillators stay on. Idle returns to run when `irq_pend` is high or any `rst_cause` bit is set. Wake events alone do not end idle.
- R3: In run, a write with `wr_sel`=1 and `wr_data[0]`=1 while `clk_on_hf0`=1 enters suspend (mode 2). Suspend has both clocks and both oscillators off, with `reg_low_bias`=0 and `pwr_net_en`=1.
- R4: In run, a write with `wr_sel`=1 and `wr_data[1]`=1 while `clk_on_hf0`=1 enters snooze (mode 3). Snooze has the same outputs as suspend except that `reg_low_bias`=1.
- R5: A suspend or snooze write made while `clk_on_hf0`=0 leaves the mode at run and sets `clkhalt_err`. The flag stays set through later mode changes until `rst_n` is asserted.
- R6: In suspend or snooze, any high `wake_ev` bit moves to the wake state (mode 6), and so does a high-to-low change of `cmp0_lvl`. A steady `cmp0_lvl` does not wake. The `wake_ev` bits are: 0 timer event, 1 SPI activity, 2 I2C slave activity, 3 port match, 4 interrupt-enabled logic event.
- R7: In the wake state the oscillator enables are on, both clocks are off and pins are not retained. The state moves to run on the edge where `osc_ready` is sampled high, and it stays in the wake state otherwise.
- R8: In run, a write with `wr_sel`=0 and `wr_data[1]`=1 while `deep_off_sel`=0 enters stop (mode 4). In stop `pwr_net_en`=0, `pin_retain`=1 and every clock and oscillator is off. Wake events are ignored, and any `rst_cause` bit moves to the wake state.
- R9: The same write with `deep_off_sel`=1 enters shutdown (mode 5), which has the same outputs as stop. Only `rst_cause[0]` (power-on) or `rst_cause[1]` (pin) moves to the wake state. Bits 2 (watchdog) and 3 (software) are ignored.
- R10: When both bits of a write are set, stop takes priority over idle for `wr_sel`=0, and snooze takes priority over suspend for `wr_sel`=1.
- R11: Register writes act only in run. In suspend, snooze, stop, shutdown and wake, writes and `irq_pend` have no effect on the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Active-low controller reset |
| wr_en | input | 1 | Control register write strobe |
| wr_sel | input | 1 | 0: idle/stop register, 1: suspend/snooze register |
| wr_data | input | 2 | Write data (bit 0 idle/suspend, bit 1 stop/snooze) |
| clk_on_hf0 | input | 1 | System clock is on the primary HF oscillator |
| deep_off_sel | input | 1 | Stop write selects shutdown when high |
| irq_pend | input | 1 | An interrupt is pending |
| wake_ev | input | 5 | Wake events for clock-halt modes |
| cmp0_lvl | input | 1 | Comparator 0 output level |
| osc_ready | input | 1 | Oscillators have settled |
| rst_cause | input | 4 | Reset causes: 0 power-on, 1 pin, 2 watchdog, 3 software |
| core_clk_en | output | 1 | Core clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| hfosc0_en | output | 1 | Primary HF oscillator enable |
| hfosc1_en | output | 1 | Secondary HF oscillator enable |
| reg_low_bias | output | 1 | Regulator low-bias select |
| pwr_net_en | output | 1 | Internal power nets enabled |
| pin_retain | output | 1 | Pins hold their state |
| mode | output | 3 | Current mode code |
| clkhalt_err | output | 1 | Sticky refused clock-halt entry flag |

## Verification
Each mode change, and the error flag it may set, is registered, so it shows one rising edge after the input that causes it. The enables follow combinationally from the mode. A wake from a clock-halt or power-off mode takes at least two edges: the first reaches the wake state, and the second reaches run once `osc_ready` is high. The comparator edge is caught by comparing the current level with the level held from the previous edge. The bench applies each input at a falling edge and compares `mode`, `clkhalt_err` and every enable at the next falling edge. Each step, including each half of a wake, is therefore its own row in the stimulus table.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

    localparam int CTRL_W      = 2;
    localparam int NUM_WAKE    = 5;
    localparam int NUM_RST     = 4;
    localparam int MODE_W      = 3;

    // write-data bit positions (software-visible encoding)
    localparam int IDLE_BIT    = 0;  // wr_sel = 0
    localparam int STOP_BIT    = 1;  // wr_sel = 0
    localparam int SUSP_BIT    = 0;  // wr_sel = 1
    localparam int SNZ_BIT     = 1;  // wr_sel = 1

    // reset causes that may leave shutdown: power-on and pin
    localparam int RST_POR_BIT = 0;
    localparam int RST_PIN_BIT = 1;

    typedef enum logic [MODE_W-1:0] {
        PM_RUN      = 3'd0,
        PM_IDLE     = 3'd1,
        PM_SUSPEND  = 3'd2,
        PM_SNOOZE   = 3'd3,
        PM_STOP     = 3'd4,
        PM_SHUTDOWN = 3'd5,
        PM_WAKE     = 3'd6
    } pm_state_e;

    typedef struct packed {
        logic core_clk;
        logic periph_clk;
        logic osc0;
        logic osc1;
        logic low_bias;
        logic pwr_net;
        logic retain;
    } pm_ctl_t;

endpackage

// File: rtl/pm_wake_collect.sv
module pm_wake_collect
    import pwr_mode_pkg::*;
#(
    parameter int N_EV = NUM_WAKE
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_EV-1:0] wake_ev,
    input  logic            cmp0_lvl,
    output logic            wake_hit
);

    typedef struct packed {
        logic cmp_prev;
    } wk_t;

    wk_t wk_d, wk_q;
    logic cmp_fall;

    always_comb begin
        wk_d          = wk_q;
        wk_d.cmp_prev = cmp0_lvl;
        cmp_fall      = wk_q.cmp_prev & ~cmp0_lvl;
        wake_hit      = (|wake_ev) | cmp_fall;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wk_q <= '0;
        else        wk_q <= wk_d;
    end

endmodule

// File: rtl/pm_mode_fsm.sv
module pm_mode_fsm
    import pwr_mode_pkg::*;
#(
    parameter int N_RST = NUM_RST
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              clk_on_hf0,
    input  logic              deep_off_sel,
    input  logic              irq_pend,
    input  logic              wake_hit,
    input  logic              osc_ready,
    input  logic [N_RST-1:0]  rst_cause,
    output pm_state_e         state_o,
    output logic              err_o
);

    localparam logic [N_RST-1:0] HARD_MASK =
        N_RST'((1 << RST_POR_BIT) | (1 << RST_PIN_BIT));

    typedef struct packed {
        pm_state_e state;
        logic      err;
    } fsm_t;

    fsm_t fsm_d, fsm_q;
    logic any_rst, hard_rst;

    always_comb begin
        fsm_d    = fsm_q;
        any_rst  = |rst_cause;
        hard_rst = |(rst_cause & HARD_MASK);
        unique case (fsm_q.state)
            PM_RUN: begin
                if (wr_en && !wr_sel) begin
                    if (wr_data[STOP_BIT])
                        fsm_d.state = deep_off_sel ? PM_SHUTDOWN : PM_STOP;
                    else if (wr_data[IDLE_BIT])
                        fsm_d.state = PM_IDLE;
                end else if (wr_en && wr_sel) begin
                    if (wr_data[SNZ_BIT] || wr_data[SUSP_BIT]) begin
                        if (clk_on_hf0)
                            fsm_d.state = wr_data[SNZ_BIT] ? PM_SNOOZE : PM_SUSPEND;
                        else
                            fsm_d.err = 1'b1;
                    end
                end
            end
            PM_IDLE: begin
                if (irq_pend || any_rst) fsm_d.state = PM_RUN;
            end
            PM_SUSPEND, PM_SNOOZE: begin
                if (wake_hit || any_rst) fsm_d.state = PM_WAKE;
            end
            PM_STOP: begin
                if (any_rst) fsm_d.state = PM_WAKE;
            end
            PM_SHUTDOWN: begin
                if (hard_rst) fsm_d.state = PM_WAKE;
            end
            PM_WAKE: begin
                if (osc_ready) fsm_d.state = PM_RUN;
            end
            default: fsm_d.state = PM_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= '{state: PM_RUN, err: 1'b0};
        else        fsm_q <= fsm_d;
    end

    assign state_o = fsm_q.state;
    assign err_o   = fsm_q.err;

    // R3 / R4: clock-halt entry only with the system clock on the primary oscillator
    a_r3_halt_needs_hf0: assert property (@(posedge clk) disable iff (!rst_n)
        ((fsm_q.state == PM_SUSPEND || fsm_q.state == PM_SNOOZE) && $past(fsm_q.state) == PM_RUN)
        |-> $past(clk_on_hf0));

    // R5: refused-entry flag is sticky
    a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_q.err |=> fsm_q.err);

    // R7: clocks come back only after the oscillator is ready
    a_r7_ready_before_run: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.state == PM_RUN && $past(fsm_q.state) == PM_WAKE) |-> $past(osc_ready));

    // R9: shutdown ends only on power-on or pin reset
    a_r9_shutdown_exit: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fsm_q.state) == PM_SHUTDOWN && fsm_q.state != PM_SHUTDOWN)
        |-> ($past(rst_cause & HARD_MASK) != '0));

    // R11: low-power modes are entered from run only
    a_r11_entry_from_run: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.state != $past(fsm_q.state) && fsm_q.state != PM_RUN && fsm_q.state != PM_WAKE)
        |-> $past(fsm_q.state) == PM_RUN);

    // R2: idle ends only on an interrupt or a reset cause
    a_r2_idle_exit: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fsm_q.state) == PM_IDLE && fsm_q.state != PM_IDLE)
        |-> ($past(irq_pend) || $past(rst_cause) != '0));

endmodule

// File: rtl/pm_out_decode.sv
module pm_out_decode
    import pwr_mode_pkg::*;
(
    input  pm_state_e state_i,
    output pm_ctl_t   ctl_o
);

    always_comb begin
        ctl_o = '0;
        unique case (state_i)
            PM_RUN:      ctl_o = '{core_clk: 1'b1, periph_clk: 1'b1, osc0: 1'b1, osc1: 1'b1,
                                   low_bias: 1'b0, pwr_net: 1'b1, retain: 1'b0};
            PM_IDLE:     ctl_o = '{core_clk: 1'b0, periph_clk: 1'b1, osc0: 1'b1, osc1: 1'b1,
                                   low_bias: 1'b0, pwr_net: 1'b1, retain: 1'b0};
            PM_SUSPEND:  ctl_o = '{core_clk: 1'b0, periph_clk: 1'b0, osc0: 1'b0, osc1: 1'b0,
                                   low_bias: 1'b0, pwr_net: 1'b1, retain: 1'b0};
            PM_SNOOZE:   ctl_o = '{core_clk: 1'b0, periph_clk: 1'b0, osc0: 1'b0, osc1: 1'b0,
                                   low_bias: 1'b1, pwr_net: 1'b1, retain: 1'b0};
            PM_STOP,
            PM_SHUTDOWN: ctl_o = '{core_clk: 1'b0, periph_clk: 1'b0, osc0: 1'b0, osc1: 1'b0,
                                   low_bias: 1'b0, pwr_net: 1'b0, retain: 1'b1};
            PM_WAKE:     ctl_o = '{core_clk: 1'b0, periph_clk: 1'b0, osc0: 1'b1, osc1: 1'b1,
                                   low_bias: 1'b0, pwr_net: 1'b1, retain: 1'b0};
            default:     ctl_o = '0;
        endcase
    end

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
    import pwr_mode_pkg::*;
#(
    parameter int N_EV  = NUM_WAKE,
    parameter int N_RST = NUM_RST
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              clk_on_hf0,
    input  logic              deep_off_sel,
    input  logic              irq_pend,
    input  logic [N_EV-1:0]   wake_ev,
    input  logic              cmp0_lvl,
    input  logic              osc_ready,
    input  logic [N_RST-1:0]  rst_cause,
    output logic              core_clk_en,
    output logic              periph_clk_en,
    output logic              hfosc0_en,
    output logic              hfosc1_en,
    output logic              reg_low_bias,
    output logic              pwr_net_en,
    output logic              pin_retain,
    output logic [MODE_W-1:0] mode,
    output logic              clkhalt_err
);

    logic      wake_hit;
    pm_state_e state;
    pm_ctl_t   ctl;

    pm_wake_collect #(.N_EV(N_EV)) u_wake (
        .clk      (clk),
        .rst_n    (rst_n),
        .wake_ev  (wake_ev),
        .cmp0_lvl (cmp0_lvl),
        .wake_hit (wake_hit)
    );

    pm_mode_fsm #(.N_RST(N_RST)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_sel       (wr_sel),
        .wr_data      (wr_data),
        .clk_on_hf0   (clk_on_hf0),
        .deep_off_sel (deep_off_sel),
        .irq_pend     (irq_pend),
        .wake_hit     (wake_hit),
        .osc_ready    (osc_ready),
        .rst_cause    (rst_cause),
        .state_o      (state),
        .err_o        (clkhalt_err)
    );

    pm_out_decode u_dec (
        .state_i (state),
        .ctl_o   (ctl)
    );

    assign core_clk_en   = ctl.core_clk;
    assign periph_clk_en = ctl.periph_clk;
    assign hfosc0_en     = ctl.osc0;
    assign hfosc1_en     = ctl.osc1;
    assign reg_low_bias  = ctl.low_bias;
    assign pwr_net_en    = ctl.pwr_net;
    assign pin_retain    = ctl.retain;
    assign mode          = MODE_W'(state);

    // R8: whenever the power nets are off the pins must be held
    a_r8_retain_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_net_en |-> (pin_retain && !core_clk_en && !hfosc0_en));

endmodule

// File: tb/pwr_mode_seq_test.sv
module pwr_mode_seq_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, wr_sel = 1'b0;
    logic [1:0] wr_data = 2'b00;
    logic       clk_on_hf0 = 1'b1, deep_off_sel = 1'b0, irq_pend = 1'b0;
    logic [4:0] wake_ev = '0;
    logic       cmp0_lvl = 1'b1, osc_ready = 1'b0;
    logic [3:0] rst_cause = '0;
    logic       core_clk_en, periph_clk_en, hfosc0_en, hfosc1_en;
    logic       reg_low_bias, pwr_net_en, pin_retain, clkhalt_err;
    logic [2:0] mode;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pwr_mode_seq uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .clk_on_hf0(clk_on_hf0), .deep_off_sel(deep_off_sel), .irq_pend(irq_pend),
        .wake_ev(wake_ev), .cmp0_lvl(cmp0_lvl), .osc_ready(osc_ready), .rst_cause(rst_cause),
        .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en), .hfosc0_en(hfosc0_en),
        .hfosc1_en(hfosc1_en), .reg_low_bias(reg_low_bias), .pwr_net_en(pwr_net_en),
        .pin_retain(pin_retain), .mode(mode), .clkhalt_err(clkhalt_err)
    );

    typedef struct packed {
        logic       we;
        logic       sel;
        logic [1:0] dat;
        logic       hf0;
        logic       deep;
        logic       irq;
        logic [4:0] wk;
        logic       cmp;
        logic       rdy;
        logic [3:0] rc;
        logic [2:0] xmode;
        logic       xerr;
        logic [3:0] req;
    } row_t;

    localparam int NROWS = 32;
    // fields: we sel dat hf0 deep irq wk cmp rdy rc | expected mode err | requirement
    localparam row_t ROWS [NROWS] = '{
        '{1'b0,1'b0,2'b00,1'b1,1'b0,1'b0,5'b00000,1'b1,1'b0,4'b0000,3'd0,1'b0,4'd1},  // R1 run
        '{1'b1,1'b0,2'b01,1'b1,1'b0,1'b0,5'b00000,1'b1,1'b0,4'b0000,3'd1,1'b0,4'd2},  // R2 idle entry
        '{1'b0,1'b0,2'b00,1'b1,1'b0,1'b0,5'b00000,1'b1,1'b0,4'b0000,3'd1,1'b0,4'd2},  // R2 holds
        '{1'b0,1'b0,2'b00,1'b1,1'b0,1'b1,5'b00000,1'b1,1'b0,4'b0000,3'd0,1'b0,4'd2},  // R2 irq exit
        '{1'b1,1'b1,2'b01,1'b1,1'b0,1'b0,5'b00000,1'b1,1'b0,4'b0000,3'd2,1'b0,4'd3},  // R3 suspend
        '{1'b1,1'b0,2'b10,1'b1,1'b0,1'b1,5'b00000,1'b1,1'b0,4'b0000,3'd2,1'b0,4'd11}, // R11 ignored
        '{1'b0,1'b0,2'b00,1'b1,1'b0,1'b0,5'b00001,1'b1,1'b0,4'b0000,3'd6,1'b0,4'd6},  // R6 timer
        '{1'b0,1'b0,2'b00,1'b1,1'b0,1'b0,5'b00000,1'b1,1'b0,4'b0000,3'd6,1'b0,4'd7},  // R7 wait
        '{1'b0,1'b0,2'b00,1'b1,1'b0,1'b0,5'b00000,1'b1,1'b1,4'b0000,3'd0,1'b0,4'd7},  // R7 ready
        '{1'b1,1'b1,2'b10,1'b1,1'b0,1'b0,5'b00000,1'b1,1'b0,4'b0000,3'd3,1'b0,4'd4},  // R4 snooze
        '{1'b0,1'b0,2'b00,1'b1,1'b0,1'b0,5'b00000,1'b1,1'b0,4'b0000,3'd3,1'b0,4'd6},  // R6 steady cmp
        '{1'b0,1'b0,2'b00,1'b1,1'b0,1'b0,5'b00000,1'b0,1'b0,4'b0000,3'd6,1'b0,4'd6},  // R6 falling cmp
        '{1'b0,1'b0,2'b00,1'b1,1'b0,1'b0,5'b00000,1'b0,1'b1,4'b0000,3'd0,1'b0,4'd7},  // R7
        '{1'b0,1'b0,2'b00,1'b1,1'b0,1'b0,5'b00000,1'b1,1'b0,4'b0000,3'd0,1'b0,4'd1},  // R1 run holds
        '{1'b1,1'b1,2'b01,1'b0,1'b0,1'b0,5'b00000,1'b1,1'b0,4'b0000,3'd0,1'b1,4'd5},  // R5 refused
        '{1'b1,1'b1,2'b11,1'b1,1'b0,1'b0,5'b00000,1'b1,1'b0,4'b0000,3'd3,1'b1,4'd10}, // R10 snooze wins
        '{1'b0,1'b0,2'b00,1'b1,1'b0,1'b0,5'b10000,1'b1,1'b0,4'b0000,3'd6,1'b1,4'd6},  // R6 logic event
        '{1'b0,1'b0,2'b00,1'b1,1'b0,1'b0,5'b00000,1'b1,1'b1,4'b0000,3'd0,1'b1,4'd5},  // R5 sticky
        '{1'b1,1'b0,2'b11,1'b1,1'b0,1'b0,5'b00000,1'b1,1'b0,4'b0000,3'd4,1'b1,4'd10}, // R10 stop wins
        '{1'b0,1'b0,2'b00,1'b1,1'b0,1'b0,5'b11111,1'b1,1'b0,4'b0000,3'd4,1'b1,4'd8},  // R8 events ignored
        '{1'b0,1'b0,2'b00,1'b1,1'b0,1'b0,5'b00000,1'b1,1'b0,4'b0100,3'd6,1'b1,4'd8},  // R8 watchdog exit
        '{1'b0,1'b0,2'b00,1'b1,1'b0,1'b0,5'b00000,1'b1,1'b1,4'b0000,3'd0,1'b1,4'd7},  // R7
        '{1'b1,1'b0,2'b10,1'b1,1'b1,1'b0,5'b00000,1'b1,1'b0,4'b0000,3'd5,1'b1,4'd9},  // R9 shutdown
        '{1'b0,1'b0,2'b00,1'b1,1'b1,1'b0,5'b00000,1'b1,1'b0,4'b1100,3'd5,1'b1,4'd9},  // R9 soft/wdog ignored
        '{1'b0,1'b0,2'b00,1'b1,1'b1,1'b0,5'b00000,1'b1,1'b0,4'b0010,3'd6,1'b1,4'd9},  // R9 pin exit
        '{1'b0,1'b0,2'b00,1'b1,1'b0,1'b0,5'b00000,1'b1,1'b1,4'b0000,3'd0,1'b1,4'd7},  // R7
        '{1'b1,1'b0,2'b10,1'b1,1'b1,1'b0,5'b00000,1'b1,1'b0,4'b0000,3'd5,1'b1,4'd9},  // R9 shutdown
        '{1'b0,1'b0,2'b00,1'b1,1'b1,1'b0,5'b00000,1'b1,1'b0,4'b0001,3'd6,1'b1,4'd9},  // R9 power-on exit
        '{1'b0,1'b0,2'b00,1'b1,1'b0,1'b0,5'b00000,1'b1,1'b1,4'b0000,3'd0,1'b1,4'd7},  // R7
        '{1'b1,1'b0,2'b01,1'b1,1'b0,1'b0,5'b00000,1'b1,1'b0,4'b0000,3'd1,1'b1,4'd2},  // R2 idle
        '{1'b0,1'b0,2'b00,1'b1,1'b0,1'b0,5'b11111,1'b1,1'b0,4'b0000,3'd1,1'b1,4'd2},  // R2 events ignored
        '{1'b0,1'b0,2'b00,1'b1,1'b0,1'b0,5'b00000,1'b1,1'b0,4'b1000,3'd0,1'b1,4'd2}   // R2 reset-cause exit
    };

    // expected {core, periph, osc0, osc1, low_bias, pwr_net, retain} per mode (R1..R9)
    function automatic logic [6:0] exp_out(input logic [2:0] m);
        case (m)
            3'd0:    return 7'b1111010;
            3'd1:    return 7'b0111010;
            3'd2:    return 7'b0000010;
            3'd3:    return 7'b0000110;
            3'd4:    return 7'b0000001;
            3'd5:    return 7'b0000001;
            3'd6:    return 7'b0011010;
            default: return 7'b0000000;
        endcase
    endfunction

    task automatic check(input int req, input int tag, input logic [2:0] xm, input logic xe);
        logic [6:0] act;
        act = {core_clk_en, periph_clk_en, hfosc0_en, hfosc1_en, reg_low_bias, pwr_net_en, pin_retain};
        checks++;
        if (mode !== xm || clkhalt_err !== xe) begin
            errors++;
            $display("FAIL R%0d step %0d mode/err %0d/%0b expected %0d/%0b", req, tag, mode, clkhalt_err, xm, xe);
        end
        checks++;
        if (act !== exp_out(xm)) begin
            errors++;
            $display("FAIL R%0d step %0d enables %b expected %b", req, tag, act, exp_out(xm));
        end
    endtask

    task automatic idle_inputs();
        wr_en = 1'b0; wr_sel = 1'b0; wr_data = 2'b00; irq_pend = 1'b0;
        wake_ev = '0; osc_ready = 1'b0; rst_cause = '0; deep_off_sel = 1'b0; clk_on_hf0 = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(1, 0, 3'd0, 1'b0);  // R1 reset state
        for (int i = 0; i < NROWS; i++) begin
            wr_en = ROWS[i].we; wr_sel = ROWS[i].sel; wr_data = ROWS[i].dat;
            clk_on_hf0 = ROWS[i].hf0; deep_off_sel = ROWS[i].deep; irq_pend = ROWS[i].irq;
            wake_ev = ROWS[i].wk; cmp0_lvl = ROWS[i].cmp; osc_ready = ROWS[i].rdy;
            rst_cause = ROWS[i].rc;
            @(negedge clk);
            check(int'(ROWS[i].req), i + 1, ROWS[i].xmode, ROWS[i].xerr);
        end
        idle_inputs();
        // R5 / R1: controller reset clears the sticky flag and returns to run from snooze
        wr_en = 1'b1; wr_sel = 1'b1; wr_data = 2'b10;
        @(negedge clk);
        idle_inputs();
        check(4, 100, 3'd3, 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        check(1, 101, 3'd0, 1'b0);
        rst_n = 1'b1;
        // R11: writes in the wake state are ignored
        wr_en = 1'b1; wr_sel = 1'b1; wr_data = 2'b01;
        @(negedge clk);
        wr_en = 1'b0; wake_ev = 5'b01000;
        @(negedge clk);
        check(6, 102, 3'd6, 1'b0);
        wake_ev = '0; wr_en = 1'b1; wr_sel = 1'b0; wr_data = 2'b10;
        @(negedge clk);
        check(11, 103, 3'd6, 1'b0);
        wr_en = 1'b0; osc_ready = 1'b1;
        @(negedge clk);
        check(7, 104, 3'd0, 1'b0);
        idle_inputs();
        // R6: a rising comparator edge does not wake snooze
        cmp0_lvl = 1'b0;
        wr_en = 1'b1; wr_sel = 1'b1; wr_data = 2'b10;
        @(negedge clk);
        wr_en = 1'b0; cmp0_lvl = 1'b1;
        @(negedge clk);
        check(6, 105, 3'd3, 1'b0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog expired actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule